// File: doc/BRIEF.md
# Vector Single-to-Half Narrowing Converter

The block takes a 128-bit vector of four IEEE-754 single-precision numbers and reduces each lane to IEEE-754 half precision. All four lanes are converted in parallel by identical combinational converters. The four 16-bit results are packed into a 64-bit word, which is merged into one half of a 128-bit destination value and registered.

A part-select input picks where the result goes. With the select low, the result fills the low half and the high half becomes zero. With the select high, the result fills the high half and the low half keeps the destination's current low half, which the caller supplies. Rounding follows a 2-bit mode input that can change on every operation.

Exception conditions from every lane are collected in a sticky flag register. That register keeps its bits until an explicit clear.

Top module: `vec_narrow_cvt`

## Requirements
- R1: Lane i of the source, at bits [32i+31:32i], is converted and placed at bits [16i+15:16i] of the 64-bit packed result, for i = 0..3.
- R2: With `upperSel` = 0, `dstOut[63:0]` is the packed result and `dstOut[127:64]` is zero.
- R3: With `upperSel` = 1, `dstOut[127:64]` is the packed result and `dstOut[63:0]` equals `dstLowIn` as sampled with the operation.
- R4: `roundMode` selects the rounding applied to each lane. 00 is nearest with ties to even, 01 is toward +infinity, 10 is toward -infinity and 11 is toward zero.
- R5: A result whose rounded magnitude exceeds 65504 becomes infinity or 0x7BFF in magnitude, sign kept, according to the rounding direction. It sets overflow and inexact. Flag bits are: [0] inexact, [1] underflow, [2] overflow, [3] invalid.
- R6: Magnitudes below 2^-14 are rounded correctly to a half subnormal, zero, or 2^-14. Underflow is set when the value is tiny before rounding and the result is inexact.
- R7: A NaN input gives a NaN with the quiet bit set, the input sign kept, and input mantissa bits [21:13] as the low nine result bits. A signaling NaN input, meaning mantissa bit 22 is clear, sets invalid.
- R8: Infinities and signed zeros convert exactly and raise no flag. Exact finite results raise no flag.
- R9: The flags hold the OR of all lane flags of every operation since the last clear. `flagClr` empties them. When `flagClr` and `inValid` fall in the same cycle, only that operation's flags remain.
- R10: `dstOut`, `flags` and `outValid` are zero after reset. A result appears in the cycle after `inValid`, with `outValid` high for that one cycle. Otherwise `dstOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Starts one conversion this cycle |
| srcVec | input | 128 | Four single-precision lanes |
| dstLowIn | input | 64 | Current low half of the destination |
| upperSel | input | 1 | 0: write low half and zero high half; 1: write high half |
| roundMode | input | 2 | Rounding mode for this operation |
| flagClr | input | 1 | Clears the sticky flags |
| dstOut | output | 128 | New destination value |
| outValid | output | 1 | dstOut updated by an operation in this cycle |
| flags | output | 4 | Sticky exception flags |

## Verification
The hardest conditions to reach from the ports sit at the edges of the half range. One is a value that rounds up across the largest finite half, such as 65520. It overflows under two rounding modes and stays finite under the other two. Another is a value just under 2^-14, which is tiny before rounding yet rounds up to the smallest normal. The stimulus sends these exact bit patterns, together with ties and sticky-only cases, through all four rounding modes. Lanes of mixed sign share each operation, so a single vector shows the direction dependence.

// File: rtl/narrow_pkg.sv
package narrow_pkg;
  localparam int NUM_LANES = 4;
  localparam int SRC_W     = 32;
  localparam int DST_W     = SRC_W / 2;
  localparam int PACK_W    = NUM_LANES * DST_W;
  localparam int VEC_W     = NUM_LANES * SRC_W;
  localparam int FLAG_W    = 4;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_UP      = 2'b01,
    RND_DOWN    = 2'b10,
    RND_ZERO    = 2'b11
  } rndMode_e;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } laneFlags_t;

  typedef struct packed {
    logic capture;
    logic clear;
  } ctrlStrobes_t;
endpackage

// File: rtl/narrow_lane.sv
module narrow_lane
  import narrow_pkg::*;
(
  input  logic [31:0] srcBits,
  input  rndMode_e    rndMode,
  output logic [15:0] halfBits,
  output laneFlags_t  laneFlags
);
  logic              sgn;
  logic [7:0]        expIn;
  logic [22:0]       manIn;
  logic signed [9:0] halfExp;
  logic signed [9:0] negExp;
  logic [3:0]        shRel;
  logic [23:0]       sig24;
  logic [35:0]       subExt;
  logic              isNormal;
  logic              lsbBit, guardBit, stickyBit;
  logic              incr;
  logic [14:0]       baseVal;
  logic [14:0]       rounded;
  logic              ovfPre, ovfPost, toInf;

  assign sgn   = srcBits[31];
  assign expIn = srcBits[30:23];
  assign manIn = srcBits[22:0];

  // exponent rebiased for the half format
  assign halfExp = $signed({2'b00, expIn}) - 10'sd112;
  assign negExp  = -halfExp;
  assign isNormal = (halfExp >= 10'sd1);

  // subnormal alignment: shift beyond 14 is relative, capped where all bits are sticky
  assign shRel  = (negExp > 10'sd12) ? 4'd12 : negExp[3:0];
  assign sig24  = {|expIn, manIn};
  assign subExt = {sig24, 12'b0} >> shRel;

  always_comb begin
    if (isNormal) begin
      lsbBit    = manIn[13];
      guardBit  = manIn[12];
      stickyBit = |manIn[11:0];
      baseVal   = {halfExp[4:0], manIn[22:13]};
    end else begin
      lsbBit    = subExt[26];
      guardBit  = subExt[25];
      stickyBit = |subExt[24:0];
      baseVal   = {5'b0, subExt[35:26]};
    end
  end

  always_comb begin
    unique case (rndMode)
      RND_NEAREST: incr = guardBit & (stickyBit | lsbBit);
      RND_UP:      incr = ~sgn & (guardBit | stickyBit);
      RND_DOWN:    incr = sgn & (guardBit | stickyBit);
      default:     incr = 1'b0;
    endcase
  end

  assign rounded = baseVal + {14'b0, incr};
  assign ovfPre  = (halfExp >= 10'sd31);
  assign ovfPost = isNormal & (rounded[14:10] == 5'h1f);
  assign toInf   = (rndMode == RND_NEAREST) |
                   ((rndMode == RND_UP) & ~sgn) |
                   ((rndMode == RND_DOWN) & sgn);

  always_comb begin
    laneFlags = '0;
    if (expIn == 8'hff) begin
      if (manIn != 23'b0) begin
        halfBits = {sgn, 5'h1f, 1'b1, manIn[21:13]};
        laneFlags.invalid = ~manIn[22];
      end else begin
        halfBits = {sgn, 15'h7c00};
      end
    end else if (ovfPre | ovfPost) begin
      halfBits = {sgn, toInf ? 15'h7c00 : 15'h7bff};
      laneFlags.overflow = 1'b1;
      laneFlags.inexact  = 1'b1;
    end else begin
      halfBits = {sgn, rounded};
      laneFlags.inexact   = guardBit | stickyBit;
      laneFlags.underflow = ~isNormal & (guardBit | stickyBit);
    end
  end
endmodule

// File: rtl/narrow_ctrl.sv
module narrow_ctrl
  import narrow_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         flagClr,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  assign strobes.capture = inValid;
  assign strobes.clear   = flagClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R10
endmodule

// File: rtl/narrow_datapath.sv
module narrow_datapath
  import narrow_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [VEC_W-1:0]   srcVec,
  input  logic [PACK_W-1:0]  dstLowIn,
  input  logic               upperSel,
  input  rndMode_e           rndMode,
  output logic [2*PACK_W-1:0] dstOut,
  output logic [FLAG_W-1:0]  flagsOut
);
  logic [PACK_W-1:0]   packedHalf;
  laneFlags_t          laneFl [NUM_LANES];
  logic [FLAG_W-1:0]   opFlags;
  logic [2*PACK_W-1:0] mergedDst;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    narrow_lane u_lane (
      .srcBits  (srcVec[i*SRC_W +: SRC_W]),
      .rndMode  (rndMode),
      .halfBits (packedHalf[i*DST_W +: DST_W]),
      .laneFlags(laneFl[i])
    );

    AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
      laneFl[i].overflow |-> (packedHalf[i*DST_W +: DST_W-1] == 15'h7c00 ||
                              packedHalf[i*DST_W +: DST_W-1] == 15'h7bff)); // R5
    AST_INVALID_GIVES_NAN: assert property (@(posedge clk) disable iff (!rstN)
      laneFl[i].invalid |-> (packedHalf[i*DST_W+10 +: 5] == 5'h1f &&
                             packedHalf[i*DST_W+9])); // R7
  end

  always_comb begin
    opFlags = '0;
    for (int i = 0; i < NUM_LANES; i++) opFlags |= laneFl[i];
  end

  assign mergedDst = upperSel ? {packedHalf, dstLowIn} : {{PACK_W{1'b0}}, packedHalf};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstOut   <= '0;
      flagsOut <= '0;
    end else begin
      if (strobes.capture) dstOut <= mergedDst;
      if (strobes.clear)
        flagsOut <= strobes.capture ? opFlags : '0;
      else if (strobes.capture)
        flagsOut <= flagsOut | opFlags;
    end
  end

  AST_LOW_MODE_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !upperSel) |=> (dstOut[2*PACK_W-1:PACK_W] == '0)); // R2
  AST_HIGH_MODE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && upperSel) |=> (dstOut[PACK_W-1:0] == $past(dstLowIn))); // R3
  AST_DST_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(dstOut)); // R10
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clear |=> ((flagsOut & $past(flagsOut)) == $past(flagsOut))); // R9
endmodule

// File: rtl/vec_narrow_cvt.sv
module vec_narrow_cvt
  import narrow_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [127:0]  srcVec,
  input  logic [63:0]   dstLowIn,
  input  logic          upperSel,
  input  logic [1:0]    roundMode,
  input  logic          flagClr,
  output logic [127:0]  dstOut,
  output logic          outValid,
  output logic [3:0]    flags
);
  ctrlStrobes_t strobes;

  narrow_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .flagClr (flagClr),
    .strobes (strobes),
    .outValid(outValid)
  );

  narrow_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .srcVec  (srcVec),
    .dstLowIn(dstLowIn),
    .upperSel(upperSel),
    .rndMode (rndMode_e'(roundMode)),
    .dstOut  (dstOut),
    .flagsOut(flags)
  );
endmodule

// File: tb/vec_narrow_cvt_tb.sv
module vec_narrow_cvt_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] srcVec = '0;
  logic [63:0]  dstLowIn = '0;
  logic         upperSel = 1'b0;
  logic [1:0]   roundMode = 2'b00;
  logic         flagClr = 1'b0;
  logic [127:0] dstOut;
  logic         outValid;
  logic [3:0]   flags;

  typedef struct {
    logic [127:0] dst;
    logic [3:0]   fl;
    string        tag;
  } expItem_t;

  expItem_t   sbQ[$];
  logic [3:0] modelFlags = '0;
  int         nChecks = 0;
  int         nFails = 0;
  bit         finished = 1'b0;

  vec_narrow_cvt u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcVec(srcVec),
    .dstLowIn(dstLowIn), .upperSel(upperSel), .roundMode(roundMode),
    .flagClr(flagClr), .dstOut(dstOut), .outValid(outValid), .flags(flags)
  );

  always #5 clk = ~clk;

  task automatic check(input logic ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: pushes the expected destination and flags, then pulses the operation
  task automatic runOp(input logic [127:0] src, input logic [63:0] expHalf,
                       input logic [3:0] laneFl, input logic [1:0] rm,
                       input logic up, input logic [63:0] dLow,
                       input logic clr, input string tag);
    expItem_t it;
    @(negedge clk);
    srcVec = src; dstLowIn = dLow; upperSel = up; roundMode = rm;
    flagClr = clr; inValid = 1'b1;
    modelFlags = (clr ? 4'b0 : modelFlags) | laneFl;
    it.dst = up ? {expHalf, dLow} : {64'b0, expHalf};
    it.fl  = modelFlags;
    it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
    inValid = 1'b0; flagClr = 1'b0;
  endtask

  // monitor: compares each produced result against the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbQ.size() == 0) begin
        check(1'b0, "R10 unexpected outValid", {127'b0, outValid}, 128'b0);
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        check(dstOut === it.dst, {it.tag, " dst"}, dstOut, it.dst);
        check(flags === it.fl, {it.tag, " flags R9"}, {124'b0, flags}, {124'b0, it.fl});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(dstOut === '0, "R10 reset dstOut", dstOut, 128'b0);
    check(flags === 4'b0, "R10 reset flags", {124'b0, flags}, 128'b0);
    check(outValid === 1'b0, "R10 reset outValid", {127'b0, outValid}, 128'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 lane order, low mode zeroes the high half
    runOp({32'h38800000, 32'h477FE000, 32'hC0000000, 32'h3F800000},
          64'h0400_7BFF_C000_3C00, 4'b0000, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R1 R2 low");
    // R3 high mode keeps low half
    runOp({32'h38800000, 32'h477FE000, 32'hC0000000, 32'h3F800000},
          64'h0400_7BFF_C000_3C00, 4'b0000, 2'b00, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b0, "R3 high");
    // R4 ties and sticky in each mode
    runOp({32'h3F802000, 32'hBF801000, 32'h3F801800, 32'h3F801000},
          64'h3C01_BC00_3C01_3C00, 4'b0001, 2'b00, 1'b0, 64'h0, 1'b1, "R4 nearest");
    runOp({32'h3F802000, 32'hBF801000, 32'h3F801800, 32'h3F801000},
          64'h3C01_BC00_3C01_3C01, 4'b0001, 2'b01, 1'b1, 64'hA5A5_0000_5A5A_FFFF, 1'b0, "R4 up");
    runOp({32'h3F802000, 32'hBF801000, 32'h3F801800, 32'h3F801000},
          64'h3C01_BC01_3C00_3C00, 4'b0001, 2'b10, 1'b0, 64'h0, 1'b0, "R4 down");
    runOp({32'h3F802000, 32'hBF801000, 32'h3F801800, 32'h3F801000},
          64'h3C01_BC00_3C00_3C00, 4'b0001, 2'b11, 1'b0, 64'h0, 1'b0, "R4 zero");
    // R5 overflow in each direction; 65520 stays finite when not rounding up in magnitude
    runOp({32'h3F800000, 32'h477FF000, 32'hC7C35000, 32'h47C35000},
          64'h3C00_7C00_FC00_7C00, 4'b0101, 2'b00, 1'b0, 64'h0, 1'b0, "R5 nearest");
    runOp({32'h3F800000, 32'h477FF000, 32'hC7C35000, 32'h47C35000},
          64'h3C00_7BFF_FBFF_7BFF, 4'b0101, 2'b11, 1'b0, 64'h0, 1'b1, "R5 zero");
    runOp({32'h3F800000, 32'h477FF000, 32'hC7C35000, 32'h47C35000},
          64'h3C00_7C00_FBFF_7C00, 4'b0101, 2'b01, 1'b0, 64'h0, 1'b1, "R5 up");
    runOp({32'h3F800000, 32'h477FF000, 32'hC7C35000, 32'h47C35000},
          64'h3C00_7BFF_FC00_7BFF, 4'b0101, 2'b10, 1'b0, 64'h0, 1'b1, "R5 down");
    // R6 tiny values
    runOp({32'h00000001, 32'h387FF000, 32'h33000000, 32'h33800000},
          64'h0000_0400_0000_0001, 4'b0011, 2'b00, 1'b0, 64'h0, 1'b1, "R6 nearest");
    runOp({32'h80000001, 32'h387FF000, 32'h33000000, 32'h33800000},
          64'h8000_0400_0001_0001, 4'b0011, 2'b01, 1'b0, 64'h0, 1'b1, "R6 up");
    runOp({32'h00000000, 32'h33800000, 32'h38800000, 32'h3F800000},
          64'h0000_0001_0400_3C00, 4'b0000, 2'b00, 1'b0, 64'h0, 1'b1, "R6 exact no underflow");
    // R7 NaNs
    runOp({32'h7F800000, 32'hFFC02000, 32'h7FA00000, 32'h7FC00000},
          64'h7C00_FE01_7F00_7E00, 4'b1000, 2'b00, 1'b0, 64'h0, 1'b1, "R7 nan");
    // R8 infinities and signed zeros exact, no flags
    runOp({32'h3F800000, 32'h00000000, 32'h80000000, 32'hFF800000},
          64'h3C00_0000_8000_FC00, 4'b0000, 2'b11, 1'b0, 64'h0, 1'b1, "R8 exact");

    // R9 flags set, then cleared alone; R10 destination holds with no operation
    runOp({32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h7F800001},
          64'h3C00_3C00_3C00_7E00, 4'b1000, 2'b00, 1'b0, 64'h0, 1'b0, "R7 R9 snan");
    @(negedge clk);
    held = dstOut;
    flagClr = 1'b1;
    srcVec = {4{32'h47C35000}};
    @(negedge clk);
    flagClr = 1'b0;
    check(flags === 4'b0, "R9 clear alone", {124'b0, flags}, 128'b0);
    check(dstOut === held, "R10 hold without valid", dstOut, held);
    check(outValid === 1'b0, "R10 no valid after clear", {127'b0, outValid}, 128'b0);
    modelFlags = 4'b0;

    repeat (4) @(negedge clk);
    check(sbQ.size() == 0, "R10 all results seen", sbQ.size(), 128'b0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule